// File: doc/BRIEF.md
# Video Controller CPU Register Port

This block sits between a processor bus and the rest of a tile-based video controller. It presents eight byte-wide registers, selected by a 3-bit offset. Through them software sets the display control bits and reads the frame status flags. It also loads the sprite attribute RAM, which is a 256-byte store kept inside the block, and sets the two scroll values. The last use is access to a 16 KB external video memory through an address pointer and a data window. That memory has a synchronous port: write data is taken at the clock edge, and read data appears one cycle after the request.

A timing generator outside the block supplies single-cycle pulses for vblank start, vblank end and the sprite-zero hit. The block keeps the vblank and hit flags, clears them when the status register is read, and raises an interrupt request while vblank is flagged and enabled. Every CPU access is a one-cycle strobe, and read data is valid in that same cycle. After a data-window access the port runs one more cycle in its own state machine. The CPU must leave that cycle free of any access.

The data-window state machine has three states. ST_IDLE waits for access. The transition IDLE_TO_FILL happens on a data-window read, and IDLE_TO_STEP on a data-window write. Any other cycle takes IDLE_HOLD. ST_FILL loads the read buffer from the memory and steps the pointer, then takes FILL_DONE back to ST_IDLE. ST_STEP steps the pointer after a write, then takes STEP_DONE back to ST_IDLE.

Top module: `vcp_top`

## Requirements
- R1: After reset, every register, the sprite index, the pointer, the read buffer, both flags and both scroll values are zero. The port is in ST_IDLE, and vm_we, vm_re and nmi_req are low.
- R2: Control bit 2 sets the pointer step after each data-window access: 0 adds 1, 1 adds 32. The step is taken in the cycle after the access, and the pointer wraps modulo 16384.
- R3: The pointer is loaded by two writes to offset 6. The first write keeps its bits 5:0 as the upper six pointer bits and leaves the pointer unchanged. The second write supplies the lower eight bits and loads the full pointer.
- R4: A read of offset 7 returns the buffered byte and asks the memory for the byte at the pointer. The buffer takes that byte one cycle later. The first read after the pointer is loaded therefore returns a stale byte.
- R5: A write to offset 7 drives vm_we with the pointer address and the written byte in the access cycle.
- R6: Address 0x3F10 is driven onto vm_addr as 0x3F00, for both reads and writes. All other addresses pass through unchanged.
- R7: Status bit 7 (the vblank flag) is set by vblank_start. It is cleared by vblank_end or by a read of offset 2. A set in the same cycle as a clear wins.
- R8: Status bit 6 (the hit flag) is set by spr0_hit. It is cleared by vblank_start or by a read of offset 2. vblank_start wins over a hit pulse in the same cycle, and a hit pulse wins over a status read.
- R9: A read of offset 2 resets the shared toggle, so the next write to offset 5 or offset 6 is taken as a first write. The read returns the flags as they were before the clear.
- R10: Writes to offset 5 alternate between two targets. A first write sets scroll_v, unless the value is above 239, in which case it is dropped; the toggle still advances. A second write sets scroll_h.
- R11: Offset 3 sets the 8-bit sprite index. Every read or write of offset 4 reaches the RAM byte at that index, and the index then advances by one, wrapping from 255 to 0.
- R12: nmi_req is high exactly while the vblank flag is set and control bit 7 is 1.
- R13: Offset 0 (control) and offset 1 (mask) read back their last written values. Offsets 3, 5 and 6 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_sel | input | 1 | One-cycle access strobe |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_off | input | 3 | Register offset |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid in the access cycle |
| vbl_start | input | 1 | Vblank start pulse |
| vbl_end | input | 1 | Vblank end pulse |
| spr0_hit | input | 1 | Sprite-zero hit pulse |
| vm_addr | output | 14 | Video memory address |
| vm_wdata | output | 8 | Video memory write data |
| vm_we | output | 1 | Video memory write enable |
| vm_re | output | 1 | Video memory read request |
| vm_rdata | input | 8 | Video memory read data, one cycle after vm_re |
| scroll_v | output | 8 | Vertical scroll value |
| scroll_h | output | 8 | Horizontal scroll value |
| nmi_req | output | 1 | Interrupt request |

## Verification
The bench goes after five corner cases.

- **Stale first read.** A design that fills the buffer before returning it would give the fresh byte on the first read, one read too early.
- **Pointer wrap at 0x3FFF, with both steps.** A pointer wider than 14 bits would drive an address outside the memory.
- **Scroll value of 240 versus 239.** If the toggle did not advance on a dropped write, the following horizontal write would land in the vertical value.
- **Same-cycle collisions of the flag events.** The cases are status read with vblank start, vblank start with hit, and hit with status read. A wrong priority loses a vblank or reports a hit from the old frame.
- **Palette mirror and sprite index.** The mirrored palette cell is written through one address and read through the other. The sprite index is walked across 255, so a missing fold or a missing wrap shows up as a wrong byte.

// File: rtl/vcp_pkg.sv
package vcp_pkg;

    typedef enum logic [2:0] {
        REG_CTRL = 3'd0,
        REG_MASK = 3'd1,
        REG_STAT = 3'd2,
        REG_SPA  = 3'd3,
        REG_SPD  = 3'd4,
        REG_SCRL = 3'd5,
        REG_VADR = 3'd6,
        REG_VDAT = 3'd7
    } reg_off_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_STEP = 2'd2
    } port_state_e;

    localparam int unsigned BIT_STEP32 = 2;
    localparam int unsigned BIT_NMI_EN = 7;
    localparam int unsigned BIT_VBL    = 7;
    localparam int unsigned BIT_HIT    = 6;

endpackage

// File: rtl/vcp_status.sv
module vcp_status (
    input  logic clk,
    input  logic rst_n,
    input  logic vbl_start,
    input  logic vbl_end,
    input  logic hit_evt,
    input  logic stat_rd,
    input  logic nmi_en,
    output logic vbl_q,
    output logic hit_q,
    output logic nmi
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vbl_q <= 1'b0;
            hit_q <= 1'b0;
        end else begin
            // vblank: a set wins over any clear in the same cycle
            if (vbl_start)
                vbl_q <= 1'b1;
            else if (vbl_end || stat_rd)
                vbl_q <= 1'b0;

            // hit: vblank start beats a hit pulse, a hit pulse beats a status read
            if (vbl_start)
                hit_q <= 1'b0;
            else if (hit_evt)
                hit_q <= 1'b1;
            else if (stat_rd)
                hit_q <= 1'b0;
        end
    end

    assign nmi = vbl_q & nmi_en;

    assert_vbl_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vbl_start |=> vbl_q);

    assert_vbl_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vbl_end || stat_rd) && !vbl_start |=> !vbl_q);

    assert_hit_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vbl_start |=> !hit_q);

    assert_hit_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hit_evt && !vbl_start |=> hit_q);

endmodule

// File: rtl/vcp_sprite_ram.sv
module vcp_sprite_ram #(
    parameter int unsigned DEPTH = 256,
    parameter int unsigned DW    = 8,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idx_wr,
    input  logic          data_wr,
    input  logic          data_rd,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (data_wr)
            mem[idx_q] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_q <= '0;
        else if (idx_wr)
            idx_q <= wdata[AW-1:0];
        else if (data_wr || data_rd)
            idx_q <= idx_q + 1'b1;
    end

    assign rdata = mem[idx_q];

    assert_idx_advance_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr || data_rd) && !idx_wr |=> idx_q == AW'($past(idx_q) + 1'b1));

endmodule

// File: rtl/vcp_vmem_port.sv
module vcp_vmem_port
    import vcp_pkg::*;
#(
    parameter int unsigned    AW      = 14,
    parameter int unsigned    DW      = 8,
    parameter int unsigned    VMAX    = 239,
    parameter int unsigned    ROW     = 32,
    parameter logic [AW-1:0]  PAL_BG0 = 'h3F00,
    localparam int unsigned   HI_W    = AW - DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scrl_wr,
    input  logic          vadr_wr,
    input  logic          vdat_wr,
    input  logic          vdat_rd,
    input  logic          stat_rd,
    input  logic          step32,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] vm_rdata,
    output logic [AW-1:0] vm_addr,
    output logic [DW-1:0] vm_wdata,
    output logic          vm_we,
    output logic          vm_re,
    output logic [DW-1:0] rbuf,
    output logic [DW-1:0] scroll_v,
    output logic [DW-1:0] scroll_h
);

    localparam logic [AW-1:0] PAL_SPR0  = PAL_BG0 | AW'(16);
    localparam logic [AW-1:0] ROW_STEP  = AW'(ROW);
    localparam logic [AW-1:0] UNIT_STEP = AW'(1);

    port_state_e   st_q, st_d;
    logic          toggle_q;
    logic          step_q;
    logic [HI_W-1:0] hi_q;
    logic [AW-1:0] vaddr_q;
    logic [DW-1:0] rbuf_q, sv_q, sh_q;
    logic          bump, load_buf, access;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else
            st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (vdat_rd)
                    st_d = ST_FILL;
                else if (vdat_wr)
                    st_d = ST_STEP;
            end
            ST_FILL: st_d = ST_IDLE;
            ST_STEP: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        access   = (st_q == ST_IDLE) && (vdat_rd || vdat_wr);
        vm_we    = (st_q == ST_IDLE) && vdat_wr;
        vm_re    = (st_q == ST_IDLE) && vdat_rd;
        bump     = (st_q == ST_FILL) || (st_q == ST_STEP);
        load_buf = (st_q == ST_FILL);
        vm_addr  = (vaddr_q == PAL_SPR0) ? PAL_BG0 : vaddr_q;
        vm_wdata = wdata;
    end

    // data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            toggle_q <= 1'b0;
            step_q   <= 1'b0;
            hi_q     <= '0;
            vaddr_q  <= '0;
            rbuf_q   <= '0;
            sv_q     <= '0;
            sh_q     <= '0;
        end else begin
            if (stat_rd)
                toggle_q <= 1'b0;
            else if (scrl_wr || vadr_wr)
                toggle_q <= ~toggle_q;

            if (scrl_wr) begin
                if (!toggle_q) begin
                    if (wdata <= DW'(VMAX))
                        sv_q <= wdata;
                end else begin
                    sh_q <= wdata;
                end
            end

            if (vadr_wr) begin
                if (!toggle_q)
                    hi_q <= wdata[HI_W-1:0];
                else
                    vaddr_q <= {hi_q, wdata};
            end else if (bump) begin
                vaddr_q <= vaddr_q + (step_q ? ROW_STEP : UNIT_STEP);
            end

            if (access)
                step_q <= step32;

            if (load_buf)
                rbuf_q <= vm_rdata;
        end
    end

    assign rbuf     = rbuf_q;
    assign scroll_v = sv_q;
    assign scroll_h = sh_q;

    assert_ptr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE) && !vadr_wr |=>
            vaddr_q == AW'($past(vaddr_q) + ($past(step_q) ? ROW_STEP : UNIT_STEP)));

    assert_toggle_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> !toggle_q);

    assert_vscroll_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        scrl_wr && !toggle_q && (wdata > DW'(VMAX)) |=> $stable(sv_q));

    assert_fill_return_R4: assert property (@(posedge clk) disable iff (!rst_n)
        vm_re |=> st_q == ST_FILL);

    assert_mirror_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vm_we || vm_re) |-> vm_addr != PAL_SPR0);

endmodule

// File: rtl/vcp_top.sv
module vcp_top
    import vcp_pkg::*;
#(
    parameter int unsigned ADDR_W      = 14,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SPR_BYTES   = 256,
    parameter int unsigned VSCROLL_MAX = 239
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_sel,
    input  logic              cpu_we,
    input  logic [2:0]        cpu_off,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              vbl_start,
    input  logic              vbl_end,
    input  logic              spr0_hit,
    output logic [ADDR_W-1:0] vm_addr,
    output logic [DATA_W-1:0] vm_wdata,
    output logic              vm_we,
    output logic              vm_re,
    input  logic [DATA_W-1:0] vm_rdata,
    output logic [DATA_W-1:0] scroll_v,
    output logic [DATA_W-1:0] scroll_h,
    output logic              nmi_req
);

    reg_off_e          off_e;
    logic              wr, rd;
    logic [DATA_W-1:0] ctrl_q, mask_q;
    logic [DATA_W-1:0] spr_rdata, rbuf;
    logic              vbl_flag, hit_flag;

    assign off_e = reg_off_e'(cpu_off);
    assign wr    = cpu_sel &  cpu_we;
    assign rd    = cpu_sel & ~cpu_we;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mask_q <= '0;
        end else if (wr) begin
            if (off_e == REG_CTRL) ctrl_q <= cpu_wdata;
            if (off_e == REG_MASK) mask_q <= cpu_wdata;
        end
    end

    vcp_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .vbl_start (vbl_start),
        .vbl_end   (vbl_end),
        .hit_evt   (spr0_hit),
        .stat_rd   (rd && off_e == REG_STAT),
        .nmi_en    (ctrl_q[BIT_NMI_EN]),
        .vbl_q     (vbl_flag),
        .hit_q     (hit_flag),
        .nmi       (nmi_req)
    );

    vcp_sprite_ram #(
        .DEPTH (SPR_BYTES),
        .DW    (DATA_W)
    ) u_spr (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx_wr  (wr && off_e == REG_SPA),
        .data_wr (wr && off_e == REG_SPD),
        .data_rd (rd && off_e == REG_SPD),
        .wdata   (cpu_wdata),
        .rdata   (spr_rdata)
    );

    vcp_vmem_port #(
        .AW   (ADDR_W),
        .DW   (DATA_W),
        .VMAX (VSCROLL_MAX)
    ) u_vport (
        .clk      (clk),
        .rst_n    (rst_n),
        .scrl_wr  (wr && off_e == REG_SCRL),
        .vadr_wr  (wr && off_e == REG_VADR),
        .vdat_wr  (wr && off_e == REG_VDAT),
        .vdat_rd  (rd && off_e == REG_VDAT),
        .stat_rd  (rd && off_e == REG_STAT),
        .step32   (ctrl_q[BIT_STEP32]),
        .wdata    (cpu_wdata),
        .vm_rdata (vm_rdata),
        .vm_addr  (vm_addr),
        .vm_wdata (vm_wdata),
        .vm_we    (vm_we),
        .vm_re    (vm_re),
        .rbuf     (rbuf),
        .scroll_v (scroll_v),
        .scroll_h (scroll_h)
    );

    always_comb begin
        cpu_rdata = '0;
        if (rd) begin
            unique case (off_e)
                REG_CTRL: cpu_rdata = ctrl_q;
                REG_MASK: cpu_rdata = mask_q;
                REG_STAT: begin
                    cpu_rdata[BIT_VBL] = vbl_flag;
                    cpu_rdata[BIT_HIT] = hit_flag;
                end
                REG_SPD:  cpu_rdata = spr_rdata;
                REG_VDAT: cpu_rdata = rbuf;
                default:  cpu_rdata = '0;
            endcase
        end
    end

    assert_nmi_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |-> vbl_flag);

    assert_single_port_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(vm_we && vm_re));

endmodule

// File: tb/vcp_top_tb_top.sv
module vcp_top_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cpu_sel, cpu_we;
    logic [2:0] cpu_off;
    logic [7:0] cpu_wdata, cpu_rdata;
    logic       vbl_start, vbl_end, spr0_hit;
    logic [13:0] vm_addr;
    logic [7:0] vm_wdata, vm_rdata;
    logic       vm_we, vm_re;
    logic [7:0] scroll_v, scroll_h;
    logic       nmi_req;

    always #(CLK_PERIOD/2) clk = ~clk;

    vcp_top dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_we(cpu_we),
        .cpu_off(cpu_off), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .vbl_start(vbl_start), .vbl_end(vbl_end), .spr0_hit(spr0_hit),
        .vm_addr(vm_addr), .vm_wdata(vm_wdata), .vm_we(vm_we), .vm_re(vm_re),
        .vm_rdata(vm_rdata), .scroll_v(scroll_v), .scroll_h(scroll_h),
        .nmi_req(nmi_req)
    );

    // external synchronous video memory
    logic [7:0] ext_mem [16384];
    always @(posedge clk) begin
        if (vm_we) ext_mem[vm_addr] <= vm_wdata;
        if (vm_re) vm_rdata <= ext_mem[vm_addr];
    end

    // reference model state
    int ref_mem [16384];
    int m_spr [256];
    int m_ctrl, m_mask, m_sa, m_sv, m_sh, m_hi, m_va, m_rbuf;
    bit m_vbl, m_hit, m_tog;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int fold(input int a);
        return (a == 'h3F10) ? 'h3F00 : a;
    endfunction

    function automatic int model_read(input int off);
        case (off)
            0: return m_ctrl;
            1: return m_mask;
            2: return (int'(m_vbl) << 7) | (int'(m_hit) << 6);
            4: return m_spr[m_sa];
            7: return m_rbuf;
            default: return 0;
        endcase
    endfunction

    task automatic model_update(input bit sel, input bit we, input int off,
                                input int wd, input bit vs, input bit ve, input bit ht);
        int stp;
        stp = ((m_ctrl >> 2) & 1) ? 32 : 1;
        if (sel && we) begin
            case (off)
                0: m_ctrl = wd;
                1: m_mask = wd;
                3: m_sa = wd;
                4: begin m_spr[m_sa] = wd; m_sa = (m_sa + 1) & 255; end
                5: begin
                    if (!m_tog) begin
                        if (wd <= 239) m_sv = wd;
                    end else m_sh = wd;
                    m_tog = !m_tog;
                end
                6: begin
                    if (!m_tog) m_hi = wd & 63;
                    else m_va = (m_hi << 8) | wd;
                    m_tog = !m_tog;
                end
                7: begin
                    ref_mem[fold(m_va)] = wd;
                    m_va = (m_va + stp) & 16383;
                end
                default: ;
            endcase
        end
        if (sel && !we) begin
            case (off)
                2: begin m_vbl = 0; m_hit = 0; m_tog = 0; end
                4: m_sa = (m_sa + 1) & 255;
                7: begin
                    m_rbuf = ref_mem[fold(m_va)];
                    m_va = (m_va + stp) & 16383;
                end
                default: ;
            endcase
        end
        if (ve) m_vbl = 0;
        if (vs) begin m_vbl = 1; m_hit = 0; end
        else if (ht) m_hit = 1;
    endtask

    task automatic cyc(input bit sel, input bit we, input int off, input int wd,
                       input string tag, input bit vs = 0, input bit ve = 0, input bit ht = 0);
        @(negedge clk);
        cpu_sel = sel; cpu_we = we; cpu_off = off[2:0]; cpu_wdata = wd[7:0];
        vbl_start = vs; vbl_end = ve; spr0_hit = ht;
        #1;
        if (sel && !we)
            chk({tag, " read data"}, int'(cpu_rdata), model_read(off));
        if (sel && we && off == 7) begin
            chk({tag, " write strobe"}, int'(vm_we), 1);
            chk({tag, " write address"}, int'(vm_addr), fold(m_va));
            chk({tag, " write data"}, int'(vm_wdata), wd & 255);
        end
        @(posedge clk);
        #1;
        model_update(sel, we, off, wd, vs, ve, ht);
        cpu_sel = 0; cpu_we = 0; vbl_start = 0; vbl_end = 0; spr0_hit = 0;
        // per-clock comparison against the model
        chk("R12 nmi_req", int'(nmi_req), int'(m_vbl && ((m_ctrl >> 7) & 1)));
        chk("R10 scroll_v", int'(scroll_v), m_sv);
        chk("R10 scroll_h", int'(scroll_h), m_sh);
    endtask

    task automatic idle(input string tag);
        cyc(0, 0, 0, 0, tag);
    endtask

    task automatic wr(input int off, input int wd, input string tag);
        cyc(1, 1, off, wd, tag);
        idle(tag);
    endtask

    task automatic rd(input int off, input string tag);
        cyc(1, 0, off, 0, tag);
        idle(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16384; i++) begin
            ext_mem[i] = 8'((i * 7 + 3) & 255);
            ref_mem[i] = (i * 7 + 3) & 255;
        end
        m_ctrl = 0; m_mask = 0; m_sa = 0; m_sv = 0; m_sh = 0;
        m_hi = 0; m_va = 0; m_rbuf = 0; m_vbl = 0; m_hit = 0; m_tog = 0;
        vm_rdata = 0;
        rst_n = 0; cpu_sel = 0; cpu_we = 0; cpu_off = 0; cpu_wdata = 0;
        vbl_start = 0; vbl_end = 0; spr0_hit = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1 reset state
        #1;
        chk("R1 nmi_req", int'(nmi_req), 0);
        chk("R1 vm_we", int'(vm_we), 0);
        chk("R1 vm_re", int'(vm_re), 0);
        chk("R1 scroll_v", int'(scroll_v), 0);
        rd(2, "R1");
        rd(0, "R1");
        rd(7, "R1");

        // R13 register readback
        wr(1, 'h1E, "R13");
        rd(1, "R13");
        rd(3, "R13");
        rd(5, "R13");
        rd(6, "R13");

        // R3 / R5 pointer load and writes, R2 step of one
        wr(6, 'hE1, "R3");
        wr(6, 'h05, "R3");
        wr(7, 'hA0, "R5");
        wr(7, 'hA1, "R2");
        wr(7, 'hA2, "R2");

        // R4 buffered reads
        wr(6, 'h21, "R4");
        wr(6, 'h05, "R4");
        rd(7, "R4");
        rd(7, "R4");
        rd(7, "R4");
        rd(7, "R4");

        // R2 step of 32
        wr(0, 'h04, "R2");
        wr(6, 'h20, "R2");
        wr(6, 'h40, "R2");
        wr(7, 'h11, "R2");
        wr(7, 'h22, "R2");
        wr(6, 'h20, "R2");
        wr(6, 'h40, "R2");
        rd(7, "R2");
        rd(7, "R2");
        rd(7, "R2");

        // R2 wrap with both steps
        wr(0, 'h00, "R2");
        wr(6, 'h3F, "R2");
        wr(6, 'hFF, "R2");
        wr(7, 'h55, "R2");
        wr(7, 'h66, "R2");
        wr(0, 'h04, "R2");
        wr(6, 'h3F, "R2");
        wr(6, 'hF0, "R2");
        wr(7, 'h77, "R2");
        wr(7, 'h78, "R2");

        // R6 palette mirror
        wr(0, 'h00, "R6");
        wr(6, 'h3F, "R6");
        wr(6, 'h10, "R6");
        wr(7, 'h2C, "R6");
        wr(7, 'h2D, "R6");
        wr(6, 'h3F, "R6");
        wr(6, 'h00, "R6");
        rd(7, "R6");
        rd(7, "R6");
        wr(6, 'h3F, "R6");
        wr(6, 'h00, "R6");
        wr(7, 'h30, "R6");
        wr(6, 'h3F, "R6");
        wr(6, 'h10, "R6");
        rd(7, "R6");
        rd(7, "R6");

        // R10 scroll
        rd(2, "R10");
        wr(5, 240, "R10");
        wr(5, 5, "R10");
        wr(5, 239, "R10");
        wr(5, 7, "R10");

        // R9 toggle reset by status read
        wr(5, 50, "R9");
        rd(2, "R9");
        wr(5, 60, "R9");
        wr(5, 61, "R9");
        wr(6, 'h23, "R9");
        rd(2, "R9");
        wr(6, 'h01, "R9");
        wr(6, 'h40, "R9");
        wr(7, 'h99, "R9");

        // R7 / R12 vblank flag and interrupt
        wr(0, 'h80, "R12");
        cyc(0, 0, 0, 0, "R7", 1, 0, 0);
        rd(2, "R7");
        rd(2, "R7");
        cyc(1, 0, 2, 0, "R7", 1, 0, 0);
        rd(2, "R7");
        cyc(0, 0, 0, 0, "R7", 1, 0, 0);
        cyc(0, 0, 0, 0, "R7", 0, 1, 0);
        rd(2, "R7");
        wr(0, 'h00, "R12");
        cyc(0, 0, 0, 0, "R12", 1, 0, 0);
        wr(0, 'h80, "R12");
        cyc(0, 0, 0, 0, "R12", 0, 1, 0);

        // R8 hit flag
        cyc(0, 0, 0, 0, "R8", 0, 0, 1);
        rd(2, "R8");
        cyc(0, 0, 0, 0, "R8", 0, 0, 1);
        cyc(0, 0, 0, 0, "R8", 1, 0, 0);
        rd(2, "R8");
        cyc(0, 0, 0, 0, "R8", 1, 0, 1);
        rd(2, "R8");
        cyc(1, 0, 2, 0, "R8", 0, 0, 1);
        rd(2, "R8");

        // R11 sprite RAM, index wrap
        wr(3, 'hFE, "R11");
        wr(4, 'h01, "R11");
        wr(4, 'h02, "R11");
        wr(4, 'h03, "R11");
        wr(3, 'hFE, "R11");
        rd(4, "R11");
        rd(4, "R11");
        rd(4, "R11");
        wr(3, 'hFF, "R11");
        rd(4, "R11");
        rd(4, "R11");

        idle("end");
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule